// File: doc/BRIEF.md
# Card Data Phase Block Sequencer

This block paces the data phase of an SD/MMC-style card host. When a start request is accepted, it latches a transfer description: a direction bit, a two-bit lane-width code, a four-bit block-length exponent, a block count stored as count minus one, a total byte count, a data-phase flag and a trailing-clock option. It then advances on a one-cycle card-clock enable, `card_tick`. It groups card clocks into bytes according to the lane width, groups bytes into blocks and blocks into the whole transfer. At each step it emits a strobe that a neighbouring serializer or FIFO controller can follow.

The total byte count is cross-checked against the block arithmetic. If the total differs from blocks × block length, the transfer is run as one block whose length is the total. If the option is set, eight idle card clocks follow the data, or follow the start alone when no data phase is requested. A one-cycle completion pulse closes the operation. CRC, the command and response phases, and DMA belong to other blocks.

Top module: `sdx_data_seq`

## Requirements
- R1: After reset, `busy`, `done`, `blk_start`, `byte_stb`, `blk_end`, `dir_rd`, `single_blk` and `cur_blk` are all zero.
- R2: Lane-width code 0 needs 8 card ticks per byte, code 1 (4 lanes) needs 2, and code 2 (8 lanes) needs 1. The reserved code 3 behaves like code 0. `byte_stb` pulses once for each completed byte.
- R3: Without override, the block length is 2^`blk_log2` bytes and the block count is `blk_cnt_m1`+1. `blk_start` pulses on the first card tick of each block. `blk_end` pulses together with the `byte_stb` of the block's last byte.
- R4: If `data_xfer` is 1, `total_bytes` is nonzero, and `total_bytes` ≠ (`blk_cnt_m1`+1)·2^`blk_log2`, the transfer is one block of `total_bytes` bytes and `single_blk` reads 1. Otherwise `single_blk` reads 0.
- R5: If `data_xfer` is 0 or `total_bytes` is 0, no data phase runs: no `blk_start`, `byte_stb` or `blk_end` pulse occurs.
- R6: If `pad_en` is 1, exactly eight further card ticks are consumed after the data phase (or after the start when there is no data phase) before completion.
- R7: `done` is high for exactly one cycle, with `busy` low, in the cycle after the state that follows the final consumed card tick. Without padding, `done` is high in the cycle right after the last `blk_end` pulse.
- R8: A start is accepted only while `busy` is 0. `busy` is 1 from the cycle after an accepted start until `done`. A start while busy changes neither the configuration nor the counts of the running transfer.
- R9: `dir_rd` holds the `rd` value latched at the accepted start (1 = card to host) until the next accepted start.
- R10: While `blk_end` is high, `cur_blk` equals the zero-based index of the block just ended.
- R11: Cycles with `card_tick` low do not advance the sequence. The total number of ticks consumed is bytes × ticks-per-byte, plus 8 if padding is enabled, for any tick spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an operation |
| data_xfer | input | 1 | A data phase follows |
| rd | input | 1 | 1 = card to host, 0 = host to card |
| width_code | input | 2 | Lane width: 0 = 1 bit, 1 = 4 bits, 2 = 8 bits |
| blk_log2 | input | 4 | log2 of block length in bytes |
| blk_cnt_m1 | input | CNT_W | Number of blocks minus one |
| total_bytes | input | TOT_W | Total byte count of the transfer |
| pad_en | input | 1 | Append eight idle card clocks |
| card_tick | input | 1 | One-cycle enable per card clock |
| busy | output | 1 | Operation in progress |
| dir_rd | output | 1 | Latched direction |
| single_blk | output | 1 | Override to a single block is active |
| blk_start | output | 1 | First card clock of a block |
| byte_stb | output | 1 | A byte completed |
| blk_end | output | 1 | Last byte of a block completed |
| cur_blk | output | CNT_W | Index of the block being moved |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check these local properties: `done` is a single-cycle pulse seen with `busy` low; `blk_end` never appears without `byte_stb`; every byte strobe follows a sampled card tick; configuration outputs stay steady when a start arrives during a busy operation; and the tick and pad counters stay within bounds. Only the bench scenarios can show the arithmetic outcomes. These are the number of card ticks consumed for each width and padding choice, the number of blocks and bytes under matching and mismatching totals, the skipped data phase, the block ordering in `cur_blk`, and the immunity of a running transfer to a second start.

// File: rtl/sdx_pkg.sv
package sdx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_PAD  = 2'd2,
        ST_FIN  = 2'd3
    } seq_state_t;

    localparam int PAD_CLOCKS = 8;

    typedef struct packed {
        logic       rd;
        logic       pad;
        logic       single;
        logic [1:0] width;
    } seq_flags_t;

    // card clocks needed to move one byte for a lane-width code
    function automatic logic [3:0] ticks_per_byte(input logic [1:0] code);
        case (code)
            2'd1:    ticks_per_byte = 4'd2;
            2'd2:    ticks_per_byte = 4'd1;
            default: ticks_per_byte = 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/sdx_cfg_decode.sv
module sdx_cfg_decode #(
    parameter int CNT_W = 8,
    parameter int TOT_W = 16,
    parameter int LEN_W = 16
) (
    input  logic             data_xfer,
    input  logic [3:0]       blk_log2,
    input  logic [CNT_W-1:0] blk_cnt_m1,
    input  logic [TOT_W-1:0] total_bytes,
    output logic             skip_data,
    output logic             single,
    output logic [LEN_W-1:0] len_m1,
    output logic [CNT_W-1:0] last_blk
);
    localparam int PW = CNT_W + 16;
    localparam int CW = (PW > TOT_W) ? PW : TOT_W;

    logic [CNT_W:0]   nblk;
    logic [CW-1:0]    prod;
    logic [CW-1:0]    tot_x;
    logic [LEN_W-1:0] len_pow;
    logic             tot_zero;

    always_comb begin
        nblk      = {1'b0, blk_cnt_m1} + (CNT_W+1)'(1);
        prod      = CW'(nblk) << blk_log2;
        tot_x     = CW'(total_bytes);
        len_pow   = LEN_W'(1) << blk_log2;
        tot_zero  = (total_bytes == '0);
        skip_data = !data_xfer || tot_zero;
        single    = !skip_data && (tot_x != prod);
        len_m1    = single ? (LEN_W'(total_bytes) - LEN_W'(1)) : (len_pow - LEN_W'(1));
        last_blk  = single ? '0 : blk_cnt_m1;
    end

endmodule

// File: rtl/sdx_byte_pacer.sv
module sdx_byte_pacer
    import sdx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       adv,
    input  logic [1:0] width_code,
    output logic       first_tick,
    output logic       byte_done
);
    logic [2:0] tick_cnt;
    logic [3:0] tpb;

    always_comb begin
        tpb        = ticks_per_byte(width_code);
        first_tick = (tick_cnt == 3'd0);
        byte_done  = adv && ({1'b0, tick_cnt} == (tpb - 4'd1));
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            tick_cnt <= '0;
        end else if (adv) begin
            tick_cnt <= byte_done ? 3'd0 : tick_cnt + 3'd1;
        end
    end

    // R2: the position inside a byte never reaches the byte's tick budget
    a_r2_tick_in_range: assert property (@(posedge clk) disable iff (rst)
        !clear |-> ({1'b0, tick_cnt} < tpb));

    // R11: without a tick the position inside a byte holds
    a_r11_tick_hold: assert property (@(posedge clk) disable iff (rst)
        (!adv && !clear) |=> $stable(tick_cnt));

endmodule

// File: rtl/sdx_pad_counter.sv
module sdx_pad_counter #(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic adv,
    output logic last
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;

    logic [CW-1:0] cnt;

    assign last = adv && (cnt == CW'(N - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= last ? '0 : cnt + CW'(1);
        end
    end

    // R6: the final trailing clock wraps the counter
    a_r6_pad_wrap: assert property (@(posedge clk) disable iff (rst)
        last |=> (cnt == '0));

endmodule

// File: rtl/sdx_data_seq.sv
module sdx_data_seq
    import sdx_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int TOT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             data_xfer,
    input  logic             rd,
    input  logic [1:0]       width_code,
    input  logic [3:0]       blk_log2,
    input  logic [CNT_W-1:0] blk_cnt_m1,
    input  logic [TOT_W-1:0] total_bytes,
    input  logic             pad_en,
    input  logic             card_tick,
    output logic             busy,
    output logic             dir_rd,
    output logic             single_blk,
    output logic             blk_start,
    output logic             byte_stb,
    output logic             blk_end,
    output logic [CNT_W-1:0] cur_blk,
    output logic             done
);
    localparam int LEN_W = (TOT_W > 16) ? TOT_W : 16;

    seq_state_t       state;
    seq_flags_t       flags_q;
    logic [LEN_W-1:0] len_m1_q;
    logic [CNT_W-1:0] last_blk_q;
    logic [LEN_W-1:0] byte_idx;
    logic [CNT_W-1:0] blk_idx;

    logic             dec_skip;
    logic             dec_single;
    logic [LEN_W-1:0] dec_len_m1;
    logic [CNT_W-1:0] dec_last_blk;

    logic             data_adv;
    logic             pad_adv;
    logic             first_tick;
    logic             byte_done;
    logic             pad_last;

    sdx_cfg_decode #(.CNT_W(CNT_W), .TOT_W(TOT_W), .LEN_W(LEN_W)) u_dec (
        .data_xfer   (data_xfer),
        .blk_log2    (blk_log2),
        .blk_cnt_m1  (blk_cnt_m1),
        .total_bytes (total_bytes),
        .skip_data   (dec_skip),
        .single      (dec_single),
        .len_m1      (dec_len_m1),
        .last_blk    (dec_last_blk)
    );

    assign data_adv = (state == ST_DATA) && card_tick;
    assign pad_adv  = (state == ST_PAD) && card_tick;

    sdx_byte_pacer u_pace (
        .clk        (clk),
        .rst        (rst),
        .clear      (state != ST_DATA),
        .adv        (data_adv),
        .width_code (flags_q.width),
        .first_tick (first_tick),
        .byte_done  (byte_done)
    );

    sdx_pad_counter #(.N(PAD_CLOCKS)) u_pad (
        .clk   (clk),
        .rst   (rst),
        .clear (state != ST_PAD),
        .adv   (pad_adv),
        .last  (pad_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            flags_q    <= '0;
            len_m1_q   <= '0;
            last_blk_q <= '0;
            byte_idx   <= '0;
            blk_idx    <= '0;
            cur_blk    <= '0;
            blk_start  <= 1'b0;
            byte_stb   <= 1'b0;
            blk_end    <= 1'b0;
            done       <= 1'b0;
        end else begin
            blk_start <= 1'b0;
            byte_stb  <= 1'b0;
            blk_end   <= 1'b0;
            done      <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        flags_q.rd     <= rd;
                        flags_q.pad    <= pad_en;
                        flags_q.single <= dec_single;
                        flags_q.width  <= width_code;
                        len_m1_q       <= dec_len_m1;
                        last_blk_q     <= dec_last_blk;
                        byte_idx       <= '0;
                        blk_idx        <= '0;
                        cur_blk        <= '0;
                        if (!dec_skip) begin
                            state <= ST_DATA;
                        end else if (pad_en) begin
                            state <= ST_PAD;
                        end else begin
                            state <= ST_FIN;
                        end
                    end
                end
                ST_DATA: begin
                    if (card_tick) begin
                        cur_blk <= blk_idx;
                        if (first_tick && (byte_idx == '0)) begin
                            blk_start <= 1'b1;
                        end
                        if (byte_done) begin
                            byte_stb <= 1'b1;
                            if (byte_idx == len_m1_q) begin
                                blk_end  <= 1'b1;
                                byte_idx <= '0;
                                if (blk_idx == last_blk_q) begin
                                    state <= flags_q.pad ? ST_PAD : ST_FIN;
                                end else begin
                                    blk_idx <= blk_idx + CNT_W'(1);
                                end
                            end else begin
                                byte_idx <= byte_idx + LEN_W'(1);
                            end
                        end
                    end
                end
                ST_PAD: begin
                    if (pad_last) begin
                        state <= ST_FIN;
                    end
                end
                default: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign busy       = (state != ST_IDLE);
    assign dir_rd     = flags_q.rd;
    assign single_blk = flags_q.single;

    // R7: completion is a single pulse
    a_r7_done_one_shot: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: completion is reported once the sequencer is free
    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R3: a block ends only on a byte boundary
    a_r3_end_on_byte: assert property (@(posedge clk) disable iff (rst)
        blk_end |-> byte_stb);

    // R11: every byte strobe is caused by a sampled card clock
    a_r11_byte_needs_tick: assert property (@(posedge clk) disable iff (rst)
        byte_stb |-> $past(card_tick));

    // R8: a start during a busy operation leaves the latched setup alone
    a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(dir_rd) && $stable(single_blk)));

    // R5: no block activity outside the data phase
    a_r5_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !blk_start);

endmodule

// File: tb/sim_sdx_data_seq.sv
module sim_sdx_data_seq;
    localparam int CNT_W = 8;
    localparam int TOT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             data_xfer = 1'b0;
    logic             rd = 1'b0;
    logic [1:0]       width_code = '0;
    logic [3:0]       blk_log2 = '0;
    logic [CNT_W-1:0] blk_cnt_m1 = '0;
    logic [TOT_W-1:0] total_bytes = '0;
    logic             pad_en = 1'b0;
    logic             card_tick = 1'b0;
    logic             busy, dir_rd, single_blk, blk_start, byte_stb, blk_end, done;
    logic [CNT_W-1:0] cur_blk;

    int checks = 0;
    int failures = 0;

    // monitor state
    int  tick_period = 2;
    int  phase = 0;
    bit  prev_busy = 0;
    int  n_ticks = 0, n_bstart = 0, n_bytes = 0, n_bend = 0, n_done = 0;
    int  order_err = 0;
    int  since_end = 1000;
    int  end_to_done = -1;

    always #5 clk = ~clk;

    sdx_data_seq #(.CNT_W(CNT_W), .TOT_W(TOT_W)) u0 (
        .clk(clk), .rst(rst), .start(start), .data_xfer(data_xfer), .rd(rd),
        .width_code(width_code), .blk_log2(blk_log2), .blk_cnt_m1(blk_cnt_m1),
        .total_bytes(total_bytes), .pad_en(pad_en), .card_tick(card_tick),
        .busy(busy), .dir_rd(dir_rd), .single_blk(single_blk),
        .blk_start(blk_start), .byte_stb(byte_stb), .blk_end(blk_end),
        .cur_blk(cur_blk), .done(done)
    );

    // observation and card clock generation, all at the falling edge
    always @(negedge clk) begin
        if (prev_busy && card_tick) n_ticks++;
        if (blk_start) n_bstart++;
        if (byte_stb) n_bytes++;
        if (blk_end) begin
            if (cur_blk != CNT_W'(n_bend)) order_err++;
            n_bend++;
            since_end = 0;
        end else begin
            since_end++;
        end
        if (done) begin
            n_done++;
            end_to_done = since_end;
        end
        prev_busy = busy;
        phase = (phase + 1 >= tick_period) ? 0 : phase + 1;
        card_tick = (phase == 0);
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(input bit xf, input bit r, input int w, input int lg,
                            input int cm1, input int tot, input bit pd,
                            input int per, input bit intrude);
        int tpb, nblk, len, prod, exp_blk, exp_bytes, exp_ticks, exp_single, cyc;
        tpb  = (w == 1) ? 2 : (w == 2) ? 1 : 8;
        nblk = cm1 + 1;
        len  = 1 << lg;
        prod = nblk * len;
        if (!xf || tot == 0) begin
            exp_blk = 0; exp_bytes = 0; exp_single = 0;
        end else if (tot != prod) begin
            exp_blk = 1; exp_bytes = tot; exp_single = 1;
        end else begin
            exp_blk = nblk; exp_bytes = prod; exp_single = 0;
        end
        exp_ticks = exp_bytes * tpb + (pd ? 8 : 0);

        @(negedge clk); #1;
        tick_period = per;
        n_ticks = 0; n_bstart = 0; n_bytes = 0; n_bend = 0; n_done = 0;
        order_err = 0; end_to_done = -1;
        data_xfer = xf; rd = r; width_code = 2'(w); blk_log2 = 4'(lg);
        blk_cnt_m1 = CNT_W'(cm1); total_bytes = TOT_W'(tot); pad_en = pd;
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        chk("R8 busy after start", int'(busy), 1);
        if (intrude) begin
            repeat (3) @(negedge clk);
            #1;
            rd = ~r; data_xfer = 1'b1; blk_log2 = 4'd0; blk_cnt_m1 = '0;
            total_bytes = TOT_W'(7); pad_en = ~pd;
            start = 1'b1;
            @(negedge clk); #1;
            start = 1'b0;
        end
        cyc = 0;
        while (n_done == 0 && cyc < 20000) begin
            @(negedge clk); #1;
            cyc++;
        end
        chk("R8 watchdog", int'(cyc < 20000), 1);
        chk("R11 ticks consumed", n_ticks, exp_ticks);
        chk("R3 block starts", n_bstart, exp_blk);
        chk("R3 block ends", n_bend, exp_blk);
        chk("R2 byte strobes", n_bytes, exp_bytes);
        chk("R10 block order", order_err, 0);
        chk("R4 single_blk", int'(single_blk), exp_single);
        chk("R9 dir_rd", int'(dir_rd), int'(r));
        chk("R7 busy at done", int'(busy), 0);
        if (!pd && exp_blk > 0) chk("R7 done after last end", end_to_done, 1);
        @(negedge clk); #1;
        chk("R7 done single pulse", n_done, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 strobes", int'(blk_start | byte_stb | blk_end), 0);
        chk("R1 dir_rd/single", int'(dir_rd | single_blk), 0);
        chk("R1 cur_blk", int'(cur_blk), 0);
        rst = 1'b0;

        // R2 R3 R6 R11 sweep over widths, block sizes and counts
        for (int w = 0; w < 4; w++)
            for (int lg = 0; lg < 4; lg++)
                for (int cm1 = 0; cm1 < 3; cm1++)
                    run_case(1'b1, bit'(w ^ lg), w, lg, cm1, (cm1 + 1) << lg,
                             bit'((lg + cm1) % 2), 2 + (cm1 % 2), 1'b0);

        // R4 override: totals that disagree with the block math
        run_case(1'b1, 1'b0, 1, 2, 1, 11, 1'b0, 2, 1'b0);
        run_case(1'b1, 1'b1, 2, 3, 1, 5, 1'b1, 3, 1'b0);
        run_case(1'b1, 1'b0, 0, 0, 2, 1, 1'b0, 2, 1'b0);
        // R5 no data phase
        run_case(1'b0, 1'b1, 1, 2, 1, 8, 1'b1, 2, 1'b0);
        run_case(1'b0, 1'b0, 1, 2, 1, 8, 1'b0, 2, 1'b0);
        run_case(1'b1, 1'b1, 2, 2, 0, 0, 1'b0, 3, 1'b0);
        // R8 start during a busy transfer
        run_case(1'b1, 1'b1, 0, 2, 2, 12, 1'b0, 2, 1'b1);
        run_case(1'b1, 1'b0, 1, 1, 3, 8, 1'b1, 3, 1'b1);
        // large block length
        run_case(1'b1, 1'b1, 2, 9, 1, 1024, 1'b1, 2, 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // global watchdog
    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL R8 global watchdog expired actual=1 expected=0");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule